// File: doc/BRIEF.md
# PHY Firmware Startup Supervisor

This block decides whether the microcontroller inside an external PHY has come back to life after a reset. A one-cycle start pulse launches it. It then reads PHY registers through a single request/acknowledge port. An MDIO master, which sits outside this block, carries those transfers to the device.

The supervisor first waits for the firmware heartbeat counter to move. It then polls a firmware status byte until the value reaches a threshold. Every wait is timed in ticks of a millisecond strobe.

If the status byte never gets there in time, the block restarts the microcontroller once with a pair of writes. It lets the part settle and then runs both waits again. The result is reported as a held done flag or a held error flag, together with a 2-bit failure code: 0 none, 1 heartbeat timeout, 2 status timeout, 3 read error.

Top module: `phy_boot_supervisor`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o and req_o are 0 and code_o is 0.
- R2: The heartbeat is bits [7:0] of the register at device 3, address 0xD7EE; bits [15:8] are ignored. A zero sample before any nonzero sample keeps waiting. The first nonzero sample is latched as the reference and does not end the wait. The first later sample that differs from the reference ends the heartbeat wait successfully.
- R3: Heartbeat reads are spaced at least HB_POLL ticks apart. When a sample that does not end the wait is taken after HB_LIMIT or more ticks in this phase, the block stops with err_o=1 and code 1, and it issues no status read.
- R4: The status byte is bits [7:0] of device 3, address 0xD7FD, polled every ST_POLL ticks. An unsigned value of 0x20 or more ends the sequence with done_o=1 and code 0, and 0x1F does not.
- R5: On the first status timeout (ST_LIMIT ticks), the block writes 0x00C0 and then 0x0040 to device 3, address 0xE854. It waits at least RST_WAIT ticks and then reruns the heartbeat wait with a fresh reference, followed by the status wait.
- R6: At most one restart is made per run. A second status timeout ends the run with err_o=1 and code 2. A heartbeat timeout on the second pass ends it with code 1.
- R7: A read acknowledged with rerr_i=1 ends the run at once with err_o=1 and code 3, and no further request is issued.
- R8: done_o and err_o, together with code_o, hold their values until the next accepted start. A start_i pulse while busy_o=1 has no effect on the run.
- R9: Once raised, req_o stays high with dev_o, addr_o, we_o and wdata_o unchanged until ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, honoured when idle |
| tick_i | input | 1 | One-cycle millisecond strobe |
| req_o | output | 1 | Register transfer request |
| we_o | output | 1 | 1 write, 0 read |
| dev_o | output | 5 | Target device number |
| addr_o | output | 16 | Register address |
| wdata_o | output | 16 | Write data |
| ack_i | input | 1 | Transfer complete, one cycle |
| rdata_i | input | 16 | Read data, valid with ack_i |
| rerr_i | input | 1 | Read failed, valid with ack_i |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Firmware confirmed running |
| err_o | output | 1 | Sequence failed |
| code_o | output | 2 | Failure code |

## Verification
The bench's register model answers each request two clocks after it first sees it, and the supervisor acts on the acknowledge at the next edge. A new request therefore appears no earlier than the clock after that. Outcome flags rise on the same edge that consumes the final acknowledge and stay high, so the bench samples at falling edges once done_o or err_o is set. Timeout windows are judged by the number of ticks the bench counts between start and result, with a slack of one poll interval. The settling time after a restart is judged by the ticks between the second write's acknowledge and the next heartbeat request.

// File: rtl/phy_boot_pkg.sv
package phy_boot_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HB_RD, S_HB_GAP, S_ST_RD, S_ST_GAP, S_RS_HI, S_RS_LO, S_RS_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    C_NONE = 2'd0, C_HB_TO = 2'd1, C_ST_TO = 2'd2, C_RD_ERR = 2'd3
  } fail_code_e;
endpackage

// File: rtl/phy_boot_tick_cnt.sv
module phy_boot_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (tick_i && cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/phy_boot_hb_judge.sv
module phy_boot_hb_judge #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [SW-1:0] sample_i,
  output logic          moved_o
);
  logic [SW-1:0] ref_q;
  logic          have_q;

  assign moved_o = vld_i && have_q && (sample_i != ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      have_q <= 1'b0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (vld_i && !have_q && sample_i != '0) begin
      ref_q  <= sample_i;
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_boot_req_mux.sv
module phy_boot_req_mux
  import phy_boot_pkg::*;
#(
  parameter int          DEV_W   = 5,
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 16,
  parameter int          FW_DEV  = 3,
  parameter int          HB_ADDR = 'hD7EE,
  parameter int          ST_ADDR = 'hD7FD,
  parameter int          RS_ADDR = 'hE854,
  parameter int          RS_ARM  = 'h00C0,
  parameter int          RS_RUN  = 'h0040
) (
  input  seq_state_e        state_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    dev_o   = DEV_W'(FW_DEV);
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      S_HB_RD: begin req_o = 1'b1; addr_o = ADDR_W'(HB_ADDR); end
      S_ST_RD: begin req_o = 1'b1; addr_o = ADDR_W'(ST_ADDR); end
      S_RS_HI: begin
        req_o = 1'b1; we_o = 1'b1;
        addr_o = ADDR_W'(RS_ADDR); wdata_o = DATA_W'(RS_ARM);
      end
      S_RS_LO: begin
        req_o = 1'b1; we_o = 1'b1;
        addr_o = ADDR_W'(RS_ADDR); wdata_o = DATA_W'(RS_RUN);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_boot_supervisor.sv
module phy_boot_supervisor
  import phy_boot_pkg::*;
#(
  parameter int DEV_W     = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int SAMPLE_W  = 8,
  parameter int HB_POLL   = 100,
  parameter int HB_LIMIT  = 5000,
  parameter int ST_POLL   = 100,
  parameter int ST_LIMIT  = 2500,
  parameter int RST_WAIT  = 50,
  parameter int ST_THRESH = 'h20,
  parameter int FW_DEV    = 3,
  parameter int HB_ADDR   = 'hD7EE,
  parameter int ST_ADDR   = 'hD7FD,
  parameter int RS_ADDR   = 'hE854
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rerr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        code_o
);
  localparam int LIM_A   = (HB_LIMIT > ST_LIMIT) ? HB_LIMIT : ST_LIMIT;
  localparam int LIM_MAX = (LIM_A > RST_WAIT) ? LIM_A : RST_WAIT;
  localparam int TW      = $clog2(LIM_MAX + 1) + 1;
  localparam logic [TW-1:0] HB_POLL_C  = TW'(HB_POLL);
  localparam logic [TW-1:0] HB_LIM_C   = TW'(HB_LIMIT);
  localparam logic [TW-1:0] ST_POLL_C  = TW'(ST_POLL);
  localparam logic [TW-1:0] ST_LIM_C   = TW'(ST_LIMIT);
  localparam logic [TW-1:0] RST_WAIT_C = TW'(RST_WAIT);
  localparam logic [SAMPLE_W-1:0] THRESH_C = SAMPLE_W'(ST_THRESH);

  seq_state_e state_q;
  logic       retry_q;
  logic [TW-1:0] el_cnt, gap_cnt;
  logic [SAMPLE_W-1:0] sample;
  logic rdata_unused;
  logic hb_ack, st_ack, hb_moved, hb_enter, el_clr;

  assign sample       = rdata_i[SAMPLE_W-1:0];
  assign rdata_unused = ^rdata_i[DATA_W-1:SAMPLE_W];
  assign hb_ack       = ack_i && state_q == S_HB_RD;
  assign st_ack       = ack_i && state_q == S_ST_RD;
  // entry into a heartbeat phase: fresh reference, fresh timer
  assign hb_enter     = (state_q == S_IDLE && start_i) ||
                        (state_q == S_RS_GAP && gap_cnt >= RST_WAIT_C);
  assign el_clr       = hb_enter || (hb_ack && !rerr_i && hb_moved);
  assign busy_o       = state_q != S_IDLE;

  phy_boot_tick_cnt #(.W(TW)) u_elapsed (
    .clk_i, .rst_ni, .clr_i(el_clr), .tick_i, .cnt_o(el_cnt)
  );

  phy_boot_tick_cnt #(.W(TW)) u_gap (
    .clk_i, .rst_ni, .clr_i(ack_i), .tick_i, .cnt_o(gap_cnt)
  );

  phy_boot_hb_judge #(.SW(SAMPLE_W)) u_hb (
    .clk_i, .rst_ni, .clr_i(hb_enter), .vld_i(hb_ack && !rerr_i),
    .sample_i(sample), .moved_o(hb_moved)
  );

  phy_boot_req_mux #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW_DEV(FW_DEV),
    .HB_ADDR(HB_ADDR), .ST_ADDR(ST_ADDR), .RS_ADDR(RS_ADDR),
    .RS_ARM('h00C0), .RS_RUN('h0040)
  ) u_req (
    .state_i(state_q), .req_o, .we_o, .dev_o, .addr_o, .wdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      retry_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      code_o  <= C_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_HB_RD;
          retry_q <= 1'b0;
          done_o  <= 1'b0;
          err_o   <= 1'b0;
          code_o  <= C_NONE;
        end
        S_HB_RD: if (ack_i) begin
          if (rerr_i) begin
            state_q <= S_IDLE; err_o <= 1'b1; code_o <= C_RD_ERR;
          end else if (hb_moved) begin
            state_q <= S_ST_RD;
          end else if (el_cnt >= HB_LIM_C) begin
            state_q <= S_IDLE; err_o <= 1'b1; code_o <= C_HB_TO;
          end else begin
            state_q <= S_HB_GAP;
          end
        end
        S_HB_GAP: if (gap_cnt >= HB_POLL_C) state_q <= S_HB_RD;
        S_ST_RD: if (st_ack) begin
          if (rerr_i) begin
            state_q <= S_IDLE; err_o <= 1'b1; code_o <= C_RD_ERR;
          end else if (sample >= THRESH_C) begin
            state_q <= S_IDLE; done_o <= 1'b1;
          end else if (el_cnt >= ST_LIM_C) begin
            if (!retry_q) begin
              state_q <= S_RS_HI; retry_q <= 1'b1;
            end else begin
              state_q <= S_IDLE; err_o <= 1'b1; code_o <= C_ST_TO;
            end
          end else begin
            state_q <= S_ST_GAP;
          end
        end
        S_ST_GAP: if (gap_cnt >= ST_POLL_C) state_q <= S_ST_RD;
        S_RS_HI:  if (ack_i) state_q <= S_RS_LO;
        S_RS_LO:  if (ack_i) state_q <= S_RS_GAP;
        S_RS_GAP: if (hb_enter) state_q <= S_HB_RD;
        default:  state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_boot_supervisor_chk.sv
module phy_boot_supervisor_chk #(
  parameter int DEV_W  = 5,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ack_i,
  input logic              req_o,
  input logic              we_o,
  input logic [DEV_W-1:0]  dev_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        code_o
);
  assert_idle_noreq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o);

  assert_done_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> code_o == 2'd0 && !err_o);

  assert_err_coded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> code_o != 2'd0);

  assert_busy_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o && !err_o);

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o && $stable(code_o));

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(dev_o) &&
                        $stable(we_o) && $stable(wdata_o));
endmodule

bind phy_boot_supervisor phy_boot_supervisor_chk #(
  .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ack_i(ack_i),
  .req_o(req_o), .we_o(we_o), .dev_o(dev_o), .addr_o(addr_o),
  .wdata_o(wdata_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .code_o(code_o)
);

// File: tb/test_phy_boot_supervisor.sv
module test_phy_boot_supervisor;
  localparam int HBP = 2, HBL = 20, STP = 2, STL = 10, RW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic req_o, we_o, ack_i = 1'b0, rerr_i = 1'b0;
  logic [4:0] dev_o;
  logic [15:0] addr_o, wdata_o, rdata_i = '0;
  logic busy_o, done_o, err_o;
  logic [1:0] code_o;

  phy_boot_supervisor #(
    .HB_POLL(HBP), .HB_LIMIT(HBL), .ST_POLL(STP), .ST_LIMIT(STL), .RST_WAIT(RW)
  ) i_phy_boot_supervisor (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0, cyc = 0, n_tick = 0;
  bit finished = 1'b0;

  // register model state
  logic [15:0] hb_arr [16];
  int hb_len, hb_inc, hb_hi_vary;
  int st_pre_n, st_post_on;
  logic [7:0] st_good_v;
  int rerr_at;
  int n_hb, n_st, n_wr, n_rd, t_rs, t_hb2;
  bit restarted, inflight;
  logic [4:0] wr_dev [4];
  logic [15:0] wr_addr [4], wr_data [4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) tick_i <= (cyc % 4 == 0);

  always @(posedge clk_i) begin
    cyc++;
    if (tick_i) n_tick++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // PHY register file model: answers two clocks after a request is seen
  always @(posedge clk_i) begin
    ack_i  <= 1'b0;
    rerr_i <= 1'b0;
    if (req_o && !ack_i && !inflight) begin
      inflight <= 1'b1;
      if (restarted && !we_o && addr_o == 16'hD7EE && t_hb2 < 0) t_hb2 = n_tick;
    end else if (inflight) begin
      inflight <= 1'b0;
      ack_i    <= 1'b1;
      if (we_o) begin
        if (n_wr < 4) begin
          wr_dev[n_wr] = dev_o; wr_addr[n_wr] = addr_o; wr_data[n_wr] = wdata_o;
        end
        n_wr++;
        if (wdata_o == 16'h0040) begin restarted = 1'b1; t_rs = n_tick; end
      end else begin
        if (n_rd == rerr_at) rerr_i <= 1'b1;
        if (addr_o == 16'hD7EE) begin
          if (hb_inc != 0) rdata_i <= 16'(n_hb + 1);
          else rdata_i <= hb_arr[(n_hb < hb_len) ? n_hb : hb_len - 1] |
                          ((hb_hi_vary != 0) ? {8'(n_hb), 8'h00} : 16'h0);
          n_hb++;
        end else begin
          if (restarted && st_post_on != 0) rdata_i <= {8'hA5, st_good_v};
          else rdata_i <= (n_st < st_pre_n) ? 16'h3310 : {8'h00, st_good_v};
          n_st++;
        end
        n_rd++;
      end
    end
  end

  task automatic setup();
    for (int i = 0; i < 16; i++) hb_arr[i] = 16'h0;
    hb_len = 1; hb_inc = 1; hb_hi_vary = 0;
    st_pre_n = 0; st_post_on = 0; st_good_v = 8'h20; rerr_at = -1;
    n_hb = 0; n_st = 0; n_wr = 0; n_rd = 0; t_rs = -1; t_hb2 = -1;
    restarted = 1'b0;
  endtask

  int t0, t_end;
  task automatic run();
    @(negedge clk_i);
    start_i = 1'b1; t0 = n_tick;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 3000 && !(done_o || err_o); k++) @(negedge clk_i);
    t_end = n_tick;
  endtask

  initial begin
    setup();
    inflight = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!busy_o && !done_o && !err_o && !req_o && code_o == 0, "R1 reset",
          {busy_o, done_o, err_o, req_o, code_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!req_o && !busy_o, "R1 idle after reset", {req_o, busy_o}, 0);

    // R4 normal boot: ref=1, then 2 moves; status good on third read
    setup(); st_pre_n = 2; run();
    check(done_o && !err_o && code_o == 0, "R4 done", {done_o, err_o, code_o}, 4'b1000);
    check(n_hb == 2, "R2 heartbeat reads", n_hb, 2);
    check(n_st == 3, "R4 status reads", n_st, 3);
    check(n_wr == 0, "R5 no restart", n_wr, 0);

    // R2 zero samples skipped, reference from first nonzero
    setup(); hb_inc = 0; hb_len = 5;
    hb_arr[0] = 0; hb_arr[1] = 0; hb_arr[2] = 5; hb_arr[3] = 5; hb_arr[4] = 6;
    run();
    check(done_o && n_hb == 5, "R2 reference latch", n_hb, 5);

    // R3 stalled heartbeat, upper byte moving is ignored (R2)
    setup(); hb_inc = 0; hb_len = 1; hb_arr[0] = 16'h0007; hb_hi_vary = 1; run();
    check(err_o && code_o == 1, "R3 hb timeout code", code_o, 1);
    check(n_st == 0, "R3 no status read", n_st, 0);
    check((t_end - t0) >= HBL && (t_end - t0) <= HBL + HBP + 1, "R3 hb window",
          t_end - t0, HBL);
    check(n_hb <= HBL / HBP + 1, "R3 hb poll spacing", n_hb, HBL / HBP + 1);

    // R5/R6 status stuck at 0x1F: one restart, then code 2
    setup(); st_pre_n = 100000; st_good_v = 8'h1F; run();
    check(err_o && code_o == 2, "R6 status timeout code", code_o, 2);
    check(n_wr == 2, "R6 single restart", n_wr, 2);
    check(wr_dev[0] == 3 && wr_addr[0] == 16'hE854 && wr_data[0] == 16'h00C0,
          "R5 first write", wr_data[0], 16'h00C0);
    check(wr_dev[1] == 3 && wr_addr[1] == 16'hE854 && wr_data[1] == 16'h0040,
          "R5 second write", wr_data[1], 16'h0040);
    check(n_hb == 4, "R5 fresh heartbeat pass", n_hb, 4);
    check(t_hb2 - t_rs >= RW, "R5 settle wait", t_hb2 - t_rs, RW);

    // R5 good only after restart
    setup(); st_pre_n = 100000; st_post_on = 1; st_good_v = 8'h20; run();
    check(done_o && n_wr == 2, "R5 recover after restart", {done_o, 4'(n_wr)}, 5'h12);

    // R6 heartbeat stalls on second pass
    setup(); hb_inc = 0; hb_len = 2; hb_arr[0] = 1; hb_arr[1] = 2;
    st_pre_n = 100000; st_good_v = 8'h10; run();
    check(err_o && code_o == 1 && n_wr == 2, "R6 second-pass hb timeout", code_o, 1);

    // R4 boundary: 0xFF counts as at least 0x20
    setup(); st_pre_n = 1; st_good_v = 8'hFF; run();
    check(done_o && n_st == 2, "R4 unsigned compare", n_st, 2);

    // R7 read error on third read
    setup(); rerr_at = 2; run();
    check(err_o && code_o == 3, "R7 read error code", code_o, 3);
    repeat (20) @(negedge clk_i);
    check(n_rd == 3 && n_wr == 0 && !req_o, "R7 no further requests", n_rd, 3);
    check(err_o && code_o == 3, "R8 error held", code_o, 3);

    // R8 start while busy ignored; restart after done clears flags
    setup(); st_pre_n = 3;
    @(negedge clk_i); start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    check(!err_o && busy_o, "R8 new start clears flags", {err_o, busy_o}, 1);
    repeat (30) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    for (int k = 0; k < 3000 && !done_o; k++) @(negedge clk_i);
    check(done_o && n_hb == 2 && n_st == 4, "R8 busy start ignored", n_hb, 2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule